// File: doc/BRIEF.md
# Ping-Pong Ethernet Receive Buffer Controller

This block sits between a MAC receive datapath and software. Frame bytes arrive as a stream marked with start-of-frame and end-of-frame flags. The block packs them into 32-bit words and writes them into one of two 2 KB buffers. When a frame ends, the block sets the done flag in that buffer's status word and switches to the other buffer. While software reads one frame, the next one can arrive. Software returns a buffer by writing its status word with the done bit at zero. An interrupt is raised while any buffer holds a finished frame with its own enable set, provided the global enable is set.

A fill state machine has three states. IDLE waits for a start-of-frame. FILL stores bytes. DROP discards the rest of a rejected frame. A start-of-frame in any state checks the target buffer. If its done bit is clear, the state goes to FILL, or stays in IDLE when the same beat also carries the end flag. If the done bit is set, the frame is counted as dropped and the state goes to DROP, or stays in IDLE for a one-byte frame. From FILL and from DROP, an end-of-frame beat returns to IDLE. Bytes that arrive in IDLE without a start flag are ignored. The USE_PONG parameter set to 0 limits the block to the first buffer.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, all done bits, receive enables and the global enable are 0, irq is 0, drop_count is 0, and the first frame is stored in buffer 0.
- R2: sw_addr is a byte address. Bit 12 set selects the receive region. Bit 11 selects buffer 0 (0x1000) or buffer 1 (0x1800). Word index 511 of each buffer is its status word, at 0x17FC and 0x1FFC. Read data appears on sw_rdata in the cycle after the read request.
- R3: Status bit 0 (done) is set in the cycle after the end-of-frame byte is accepted, and only then.
- R4: Bytes are packed with the first byte in bits 31:24. A final partial word has its unused low lanes filled with zero.
- R5: With two buffers, completed frames go to buffer 0, buffer 1, buffer 0, and so on, in strict alternation.
- R6: A write to a status word copies bit 3 into that buffer's receive enable. It clears done when bit 0 is 0 and leaves done unchanged when bit 0 is 1.
- R7: A frame whose target buffer still has done set is discarded whole. drop_count goes up by one, the target does not change, and the buffer contents are not changed.
- R8: irq equals the global enable AND the OR over buffers of (done AND enable). The global enable is bit 31 of the register at 0x07F8, which can be read back.
- R9: A frame longer than 511 words keeps only its first 511 words, and the status word is never overwritten by frame data.
- R10: Software writes to buffer data words are ignored.
- R11: With USE_PONG=0, every frame uses buffer 0. A frame that arrives while buffer 0 is done is dropped, and buffer 1's status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte valid on rx_data |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| sw_sel | input | 1 | Software access request |
| sw_we | input | 1 | 1 for write, 0 for read |
| sw_addr | input | 13 | Byte address |
| sw_wdata | input | 32 | Write data |
| sw_rdata | output | 32 | Read data, one cycle after the request |
| irq | output | 1 | Receive interrupt |
| drop_count | output | 16 | Number of frames dropped (wraps) |

## Verification
A wrong target pointer shows up at the next completed frame. That frame lands in the wrong buffer, or is dropped when it should have been stored, which is visible in the status words and in drop_count one cycle after its end byte. A wrong byte-lane or word pointer corrupts the data read back from the first affected word. A corrupted done or enable flop changes irq in the very next cycle, and the status word shows the same fault on its next read.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_DROP
    } fill_state_t;

    localparam int DONE_BIT = 0;
    localparam int IE_BIT   = 3;
    localparam int GIE_BIT  = 31;

endpackage

// File: rtl/rxpp_mem.sv
module rxpp_mem #(
    parameter int IDX_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W:0]    waddr,
    input  logic [31:0]       wdata,
    input  logic              re,
    input  logic [IDX_W:0]    raddr,
    output logic [31:0]       rdata
);
    localparam int DEPTH = 2 << IDX_W;

    logic [31:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/rxpp_status.sv
module rxpp_status
    import rxpp_pkg::*;
#(
    parameter int NBUF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en,
    input  logic       set_idx,
    input  logic       sts_we,
    input  logic       sts_idx,
    input  logic       wr_done,
    input  logic       wr_ie,
    input  logic       gie_we,
    input  logic       wr_gie,
    output logic [1:0] done,
    output logic [1:0] ie,
    output logic       gie,
    output logic       irq
);
    for (genvar b = 0; b < 2; b++) begin : g_buf
        localparam logic BI = 1'(b);
        if (b < NBUF) begin : g_on
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    done[b] <= 1'b0;
                    ie[b]   <= 1'b0;
                end else begin
                    if (sts_we && sts_idx == BI) begin
                        ie[b] <= wr_ie;
                        if (!wr_done) begin
                            done[b] <= 1'b0;
                        end
                    end
                    if (set_en && set_idx == BI) begin
                        done[b] <= 1'b1;
                    end
                end
            end

            // R3: a done bit only rises after a frame completes in that buffer
            a_r3_done_source: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(done[b]) |-> ($past(set_en) && $past(set_idx) == BI));
        end else begin : g_off
            assign done[b] = 1'b0;
            assign ie[b]   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie <= 1'b0;
        end else if (gie_we) begin
            gie <= wr_gie;
        end
    end

    assign irq = gie & (|(done & ie));
endmodule

// File: rtl/rxpp_fill_fsm.sv
module rxpp_fill_fsm
    import rxpp_pkg::*;
#(
    parameter int IDX_W    = 9,
    parameter int CNT_W    = 16,
    parameter int USE_PONG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [7:0]        rx_data,
    input  logic [1:0]        buf_done,
    output logic              mem_we,
    output logic              mem_buf,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [31:0]       mem_wdata,
    output logic              frame_done,
    output logic              frame_buf,
    output logic [CNT_W-1:0]  drop_count
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] ONE  = {{(IDX_W-1){1'b0}}, 1'b1};

    fill_state_t       state_q, state_d;
    logic [31:0]       acc_q, acc_d;
    logic [1:0]        lane_q, lane_d;
    logic [IDX_W-1:0]  ptr_q, ptr_d;
    logic              tgt_q, tgt_d;
    logic [CNT_W-1:0]  drop_q;

    logic              start, start_ok, accept, flush, space;
    logic [1:0]        lane_e;
    logic [IDX_W-1:0]  ptr_e;
    logic [31:0]       word_e;

    always_comb begin
        start    = rx_valid & rx_sof;
        start_ok = start & ~buf_done[tgt_q];
        accept   = start_ok | (rx_valid & ~rx_sof & (state_q == ST_FILL));
        lane_e   = start ? 2'd0 : lane_q;
        ptr_e    = start ? '0 : ptr_q;
        word_e   = (start ? 32'd0 : acc_q) | ({rx_data, 24'd0} >> {lane_e, 3'b000});
        flush    = accept & ((lane_e == 2'd3) | rx_eof);
        space    = (ptr_e != LAST);
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            lane_q  <= '0;
            ptr_q   <= '0;
            tgt_q   <= 1'b0;
            drop_q  <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            lane_q  <= lane_d;
            ptr_q   <= ptr_d;
            tgt_q   <= tgt_d;
            if (start && !start_ok) begin
                drop_q <= drop_q + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        lane_d  = lane_q;
        ptr_d   = ptr_q;
        tgt_d   = tgt_q;
        if (start) begin
            if (!start_ok) begin
                state_d = rx_eof ? ST_IDLE : ST_DROP;
            end else begin
                state_d = rx_eof ? ST_IDLE : ST_FILL;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_FILL: if (rx_valid && rx_eof) state_d = ST_IDLE;
                ST_DROP: if (rx_valid && rx_eof) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
        if (accept) begin
            if (flush) begin
                acc_d  = '0;
                lane_d = 2'd0;
                ptr_d  = space ? ptr_e + ONE : ptr_e;
            end else begin
                acc_d  = word_e;
                lane_d = lane_e + 2'd1;
                ptr_d  = ptr_e;
            end
            if (rx_eof && USE_PONG != 0) begin
                tgt_d = ~tgt_q;
            end
        end
    end

    // outputs
    always_comb begin
        mem_we     = flush & space;
        mem_buf    = tgt_q;
        mem_idx    = ptr_e;
        mem_wdata  = word_e;
        frame_done = accept & rx_eof;
        frame_buf  = tgt_q;
        drop_count = drop_q;
    end

    // R7: never write into a buffer that still holds an unread frame
    a_r7_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !buf_done[mem_buf]);

    // R9: frame data never lands on the status word
    a_r9_status_safe: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_idx != LAST));

    if (USE_PONG != 0) begin : g_alt
        // R5: each completed frame moves the target to the other buffer
        a_r5_alternate: assert property (@(posedge clk) disable iff (!rst_n)
            frame_done |=> (tgt_q != $past(tgt_q)));
    end
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf
    import rxpp_pkg::*;
#(
    parameter int WORDS_PER_BUF = 512,
    parameter int CNT_W         = 16,
    parameter int USE_PONG      = 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rx_valid,
    input  logic                                rx_sof,
    input  logic                                rx_eof,
    input  logic [7:0]                          rx_data,
    input  logic                                sw_sel,
    input  logic                                sw_we,
    input  logic [$clog2(WORDS_PER_BUF)+3:0]    sw_addr,
    input  logic [31:0]                         sw_wdata,
    output logic [31:0]                         sw_rdata,
    output logic                                irq,
    output logic [CNT_W-1:0]                    drop_count
);
    localparam int IDX_W  = $clog2(WORDS_PER_BUF);
    localparam int ADDR_W = IDX_W + 4;
    localparam int NBUF   = (USE_PONG != 0) ? 2 : 1;
    localparam logic [IDX_W-1:0]  LAST     = {IDX_W{1'b1}};
    localparam logic [ADDR_W-1:0] GIE_ADDR = ADDR_W'(WORDS_PER_BUF * 4 - 8);

    logic              in_rx, a_buf, is_sts, is_gie;
    logic [IDX_W-1:0]  a_idx;
    logic              mem_we, mem_buf, frame_done, frame_buf;
    logic [IDX_W-1:0]  mem_idx;
    logic [31:0]       mem_wdata, mem_q, hold_q, sts_word;
    logic [1:0]        done_v, ie_v;
    logic              gie_v, rd_mem_q;
    logic              unused_wbits;

    assign unused_wbits = ^{sw_wdata[30:4], sw_wdata[2:1]};

    assign in_rx  = sw_addr[ADDR_W-1];
    assign a_buf  = sw_addr[IDX_W+2];
    assign a_idx  = sw_addr[IDX_W+1:2];
    assign is_sts = in_rx & (a_idx == LAST);
    assign is_gie = (sw_addr == GIE_ADDR);

    rxpp_fill_fsm #(
        .IDX_W    (IDX_W),
        .CNT_W    (CNT_W),
        .USE_PONG (USE_PONG)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_data    (rx_data),
        .buf_done   (done_v),
        .mem_we     (mem_we),
        .mem_buf    (mem_buf),
        .mem_idx    (mem_idx),
        .mem_wdata  (mem_wdata),
        .frame_done (frame_done),
        .frame_buf  (frame_buf),
        .drop_count (drop_count)
    );

    rxpp_mem #(
        .IDX_W (IDX_W)
    ) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({mem_buf, mem_idx}),
        .wdata (mem_wdata),
        .re    (sw_sel & ~sw_we & in_rx),
        .raddr ({a_buf, a_idx}),
        .rdata (mem_q)
    );

    rxpp_status #(
        .NBUF (NBUF)
    ) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (frame_done),
        .set_idx (frame_buf),
        .sts_we  (sw_sel & sw_we & is_sts),
        .sts_idx (a_buf),
        .wr_done (sw_wdata[DONE_BIT]),
        .wr_ie   (sw_wdata[IE_BIT]),
        .gie_we  (sw_sel & sw_we & is_gie),
        .wr_gie  (sw_wdata[GIE_BIT]),
        .done    (done_v),
        .ie      (ie_v),
        .gie     (gie_v),
        .irq     (irq)
    );

    always_comb begin
        sts_word           = '0;
        sts_word[DONE_BIT] = done_v[a_buf];
        sts_word[IE_BIT]   = ie_v[a_buf];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mem_q <= 1'b0;
            hold_q   <= '0;
        end else if (sw_sel && !sw_we) begin
            rd_mem_q <= in_rx & ~is_sts;
            if (is_sts) begin
                hold_q <= sts_word;
            end else if (is_gie) begin
                hold_q <= {gie_v, 31'd0};
            end else begin
                hold_q <= '0;
            end
        end
    end

    assign sw_rdata = rd_mem_q ? mem_q : hold_q;
endmodule

// File: tb/test_rx_pingpong_buf.sv
module test_rx_pingpong_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        sw_sel = 1'b0, sw_we = 1'b0;
    logic [12:0] sw_addr = '0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] rdata, rdata2;
    logic        irq, irq2;
    logic [15:0] drops, drops2;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0]  fb [0:2199];
    logic [31:0] d1, d2, keep0, keep1;

    always #4 clk = ~clk;

    rx_pingpong_buf i_rx_pingpong_buf (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .sw_sel(sw_sel), .sw_we(sw_we),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(rdata),
        .irq(irq), .drop_count(drops)
    );

    rx_pingpong_buf #(.USE_PONG(0)) i_rx_pingpong_buf_single (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .sw_sel(sw_sel), .sw_we(sw_we),
        .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(rdata2),
        .irq(irq2), .drop_count(drops2)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [12:0] a, output logic [31:0] v1, output logic [31:0] v2);
        @(negedge clk);
        sw_sel = 1'b1; sw_we = 1'b0; sw_addr = a;
        @(negedge clk);
        sw_sel = 1'b0;
        v1 = rdata;
        v2 = rdata2;
    endtask

    task automatic bus_write(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        sw_sel = 1'b1; sw_we = 1'b1; sw_addr = a; sw_wdata = d;
        @(negedge clk);
        sw_sel = 1'b0; sw_we = 1'b0;
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++) fb[i] = seed + 8'(i * 7);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = fb[i];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    function automatic logic [31:0] exp_word(input int len, input int k);
        logic [31:0] w = '0;
        for (int j = 0; j < 4; j++) begin
            w = {w[23:0], ((4 * k + j) < len) ? fb[4 * k + j] : 8'h00};
        end
        return w;
    endfunction

    task automatic t_reset();
        bus_read(13'h17FC, d1, d2); check("R1 status0 after reset (R2)", d1, 32'h0);
        bus_read(13'h1FFC, d1, d2); check("R1 status1 after reset", d1, 32'h0);
        bus_read(13'h07F8, d1, d2); check("R1 global enable after reset", d1, 32'h0);
        check("R1 irq after reset", {31'd0, irq}, 32'h0);
        check("R1 drop_count after reset", {16'd0, drops}, 32'h0);
    endtask

    task automatic t_first_frame();
        send_frame(6, 8'h10);
        bus_read(13'h1000, d1, d2); check("R4 buf0 word0", d1, exp_word(6, 0));
        check("R11 single buf0 word0", d2, exp_word(6, 0));
        keep0 = exp_word(6, 0);
        bus_read(13'h1004, d1, d2); check("R4 buf0 padded word1", d1, exp_word(6, 1));
        bus_read(13'h17FC, d1, d2); check("R3 status0 done (R2)", d1, 32'h1);
        check("R8 irq off with enables clear", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_second_frame();
        send_frame(9, 8'h40);
        bus_read(13'h1800, d1, d2); check("R5 buf1 word0", d1, exp_word(9, 0));
        keep1 = exp_word(9, 0);
        bus_read(13'h1808, d1, d2); check("R4 buf1 padded word2", d1, exp_word(9, 2));
        bus_read(13'h1FFC, d1, d2); check("R5 status1 done", d1, 32'h1);
        check("R11 single status1 reads zero", d2, 32'h0);
        check("R11 single drops second frame", {16'd0, drops2}, 32'd1);
    endtask

    task automatic t_drop();
        send_frame(5, 8'hA0);
        check("R7 drop_count", {16'd0, drops}, 32'd1);
        check("R11 single drop_count", {16'd0, drops2}, 32'd2);
        bus_read(13'h1000, d1, d2); check("R7 buf0 unchanged", d1, keep0);
        bus_read(13'h1800, d1, d2); check("R7 buf1 unchanged", d1, keep1);
    endtask

    task automatic t_release_irq();
        bus_write(13'h17FC, 32'h9);
        bus_read(13'h17FC, d1, d2); check("R6 done kept, enable set", d1, 32'h9);
        check("R8 irq off without global enable", {31'd0, irq}, 32'h0);
        bus_write(13'h07F8, 32'h8000_0000);
        bus_read(13'h07F8, d1, d2); check("R8 global enable readback", d1, 32'h8000_0000);
        check("R8 irq on", {31'd0, irq}, 32'h1);
        bus_write(13'h17FC, 32'h8);
        bus_read(13'h17FC, d1, d2); check("R6 done cleared", d1, 32'h8);
        check("R8 irq off after release", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_short_frame();
        send_frame(1, 8'h5C);
        check("R3 R8 irq right after end byte", {31'd0, irq}, 32'h1);
        bus_read(13'h1000, d1, d2); check("R5 R4 one-byte frame in buf0", d1, 32'h5C00_0000);
        check("R11 single one-byte frame", d2, 32'h5C00_0000);
    endtask

    task automatic t_data_write();
        bus_write(13'h1000, 32'hFFFF_FFFF);
        bus_read(13'h1000, d1, d2); check("R10 data write ignored", d1, 32'h5C00_0000);
    endtask

    task automatic t_long_frame();
        bus_write(13'h1FFC, 32'h0);
        send_frame(2100, 8'h03);
        bus_read(13'h1FF8, d1, d2); check("R9 last data word", d1, exp_word(2100, 510));
        bus_read(13'h1FFC, d1, d2); check("R9 status word intact", d1, 32'h1);
        check("R11 single drops long frame", {16'd0, drops2}, 32'd3);
        check("R7 drop_count unchanged", {16'd0, drops}, 32'd1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_frame();
        t_second_frame();
        t_drop();
        t_release_irq();
        t_short_frame();
        t_data_write();
        t_long_frame();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule